// File: doc/BRIEF.md
# Scoreboard Issue Controller

This block is the central hazard bookkeeper for a processor back end with several functional units. Decoded instructions arrive one at a time, in program order. Each one names an operation, a destination register, two source registers and the unit class that must run it. The controller accepts an instruction only when that unit is free and no instruction in flight will write the same destination. Once accepted, the instruction waits in its unit until both source values exist in the register file. The controller then grants the operand read, and this can happen out of program order. When the unit later reports that it has finished, the controller grants the result write. It holds that write back while any other unit still has to read the old contents of the destination register.

Each unit has a status record: a busy flag, the operation, the destination and source numbers, the producing unit for each source, and a ready flag for each source. A register table records which unit owns the pending write of each register. There is no forwarding: a value can be used only after its write-back has completed. The functional units, the register file and the data path are outside this block. The block only controls their timing through the grant outputs.

Top module: `sb_issue_ctrl`

## Requirements
- R1: While reset is held, and after it is released with no instruction presented, `issue_ok`, `rd_grant` and `wb_grant` are all low. The first instruction presented after reset is accepted in the cycle it is presented.
- R2: `in_unit` selects the unit (0 integer, 1 multiply, 2 add, 3 divide). That index is also the bit of `rd_grant` and `wb_grant` and the slice of `unit_op` that belong to the unit. An instruction aimed at a busy unit is refused. It is accepted in the cycle after that unit's write-back grant.
- R3: An instruction whose destination has a pending write from an active instruction is refused. It is accepted in the cycle after that writer's write-back grant.
- R4: An instruction with a source that has a pending producer gets no `rd_grant` until that producer's write-back. Its `rd_grant` comes in the cycle after the producer's write-back grant.
- R5: A later instruction whose sources are ready is granted its operand read before an earlier instruction that is still waiting on a source.
- R6: Each accepted instruction receives exactly one single-cycle `rd_grant`, and never in the cycle it was accepted. With ready sources, the grant comes in the next cycle.
- R7: A finished unit is not granted write-back while another unit has not yet read a source register equal to its destination. The grant comes in the cycle after that reader's `rd_grant`.
- R8: At most one `wb_grant` bit is high per cycle, and the lowest ready unit index wins. The losing unit is granted in the following cycle.
- R9: `wb_grant` for a unit is given only while its `unit_done` is high, and only after its operand read. Each instruction is written back once.
- R10: An instruction accepted in the same cycle as the write-back grant of one of its source producers treats that source as ready. Its `rd_grant` comes in the next cycle.
- R11: From the cycle after acceptance, the unit's `unit_op` slice carries the accepted operation code. It holds that value through the operand read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A decoded instruction is presented |
| in_op | input | OP_W | Operation code for the unit |
| in_dest | input | clog2(REG_COUNT) | Destination register |
| in_src1 | input | clog2(REG_COUNT) | First source register |
| in_src2 | input | clog2(REG_COUNT) | Second source register |
| in_unit | input | 2 | Unit class: 0 integer, 1 multiply, 2 add, 3 divide |
| unit_done | input | 4 | Per unit: execution finished, held until write-back grant |
| issue_ok | output | 1 | Presented instruction is accepted this cycle |
| rd_grant | output | 4 | Per unit: read operands from the register file this cycle |
| wb_grant | output | 4 | Per unit: write the result this cycle |
| unit_op | output | 4*OP_W | Per unit: operation code of the instruction it holds |

## Verification
Two functions can fall in the same cycle: acceptance of a new instruction and the write-back of the very instruction that produces one of its sources. The bench issues an integer producer with one-cycle latency. It then keeps the decode input idle for exactly two cycles, so the consumer is presented in the cycle of the producer's write-back grant. The bench checks that the consumer's acceptance cycle equals the logged write-back cycle, and that the consumer's read grant follows one cycle later instead of the consumer waiting forever on a producer that has already retired. A second same-cycle case, two units finishing together, is built from the unit latencies. It is judged by the one-cycle gap between the two write-back grants.

// File: rtl/sb_pkg.sv
// Shared constants and unit-class encoding for the scoreboard issue controller.
// Assumes exactly four functional units, indexed by their class code.
package sb_pkg;
    localparam int UNIT_COUNT = 4;
    localparam int UNIT_IDX_W = 2;

    typedef enum logic [UNIT_IDX_W-1:0] {
        CLS_INT = 2'd0,
        CLS_MUL = 2'd1,
        CLS_ADD = 2'd2,
        CLS_DIV = 2'd3
    } unit_cls_e;
endpackage

// File: rtl/sb_unit_slot.sv
// Status record of one functional unit: busy, operation, destination, the two
// source numbers, the producer tag of each source and the two ready flags.
// Assumes alloc never coincides with retire (the issue check uses the registered
// busy flag) and read_go only when both ready flags are set.
module sb_unit_slot #(
    parameter int RW   = 5,
    parameter int OP_W = 6,
    parameter int UW   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            alloc,
    input  logic [OP_W-1:0] alloc_op,
    input  logic [RW-1:0]   alloc_fi,
    input  logic [RW-1:0]   alloc_fj,
    input  logic [RW-1:0]   alloc_fk,
    input  logic            alloc_qj_v,
    input  logic [UW-1:0]   alloc_qj,
    input  logic            alloc_qk_v,
    input  logic [UW-1:0]   alloc_qk,
    input  logic            read_go,
    input  logic            retire,
    input  logic            bcast_v,
    input  logic [UW-1:0]   bcast_unit,
    output logic            busy,
    output logic            ops_read,
    output logic [OP_W-1:0] op,
    output logic [RW-1:0]   fi,
    output logic [RW-1:0]   fj,
    output logic [RW-1:0]   fk,
    output logic            rj,
    output logic            rk
);
    logic            qj_v, qk_v;
    logic [UW-1:0]   qj, qk;

    // Record update: allocation, operand read, producer broadcast, retirement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            ops_read <= 1'b0;
            op       <= '0;
            fi       <= '0;
            fj       <= '0;
            fk       <= '0;
            rj       <= 1'b0;
            rk       <= 1'b0;
            qj_v     <= 1'b0;
            qk_v     <= 1'b0;
            qj       <= '0;
            qk       <= '0;
        end else if (alloc) begin
            busy     <= 1'b1;
            ops_read <= 1'b0;
            op       <= alloc_op;
            fi       <= alloc_fi;
            fj       <= alloc_fj;
            fk       <= alloc_fk;
            qj_v     <= alloc_qj_v;
            qj       <= alloc_qj;
            qk_v     <= alloc_qk_v;
            qk       <= alloc_qk;
            rj       <= !alloc_qj_v;
            rk       <= !alloc_qk_v;
        end else begin
            if (retire) begin
                busy     <= 1'b0;
                ops_read <= 1'b0;
            end
            if (read_go) begin
                ops_read <= 1'b1;
                rj       <= 1'b0;
                rk       <= 1'b0;
            end
            if (bcast_v && qj_v && (qj == bcast_unit)) begin
                rj   <= 1'b1;
                qj_v <= 1'b0;
            end
            if (bcast_v && qk_v && (qk == bcast_unit)) begin
                rk   <= 1'b1;
                qk_v <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sb_result_table.sv
// Register result table: per register, a pending flag and the index of the unit
// that will write it. Three read ports look up two sources and the destination.
// Assumes REG_COUNT is a power of two and that set and clear never name the same
// register in one cycle (the issue check refuses a pending destination).
module sb_result_table #(
    parameter int REG_COUNT = 32,
    parameter int UW        = 2,
    localparam int RW       = $clog2(REG_COUNT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [RW-1:0] set_reg,
    input  logic [UW-1:0] set_unit,
    input  logic          clr_en,
    input  logic [RW-1:0] clr_reg,
    input  logic [RW-1:0] look_a,
    input  logic [RW-1:0] look_b,
    input  logic [RW-1:0] look_d,
    output logic          a_v,
    output logic [UW-1:0] a_unit,
    output logic          b_v,
    output logic [UW-1:0] b_unit,
    output logic          d_v
);
    logic          pend  [REG_COUNT];
    logic [UW-1:0] owner [REG_COUNT];

    // Ownership update: claim on issue, release on write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < REG_COUNT; r++) begin
                pend[r]  <= 1'b0;
                owner[r] <= '0;
            end
        end else begin
            if (clr_en) pend[clr_reg] <= 1'b0;
            if (set_en) begin
                pend[set_reg]  <= 1'b1;
                owner[set_reg] <= set_unit;
            end
        end
    end

    // Lookups for the presented instruction.
    assign a_v    = pend[look_a];
    assign a_unit = owner[look_a];
    assign b_v    = pend[look_b];
    assign b_unit = owner[look_b];
    assign d_v    = pend[look_d];
endmodule

// File: rtl/sb_wb_picker.sv
// Fixed-priority picker for the single result-write slot: the lowest requesting
// index wins. Also returns the index in binary for the broadcast.
module sb_wb_picker #(
    parameter int N  = 4,
    parameter int UW = 2
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  grant,
    output logic          any,
    output logic [UW-1:0] idx
);
    // Scan from the top so that the lowest requester is the one kept.
    always_comb begin
        grant = '0;
        any   = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                any      = 1'b1;
                idx      = UW'(i);
            end
        end
    end
endmodule

// File: rtl/sb_issue_ctrl.sv
// Scoreboard issue controller. It accepts decoded instructions in order and
// refuses on a structural or WAW hazard. It grants operand reads once both
// sources are produced, which resolves RAW, and it grants one result write per
// cycle, holding back any write that would overwrite a value another unit has
// yet to read (WAR). Assumes the presenter holds an instruction until issue_ok,
// and that each unit holds unit_done until its wb_grant.
// A unit freed by write-back accepts a new instruction only from the next cycle.
module sb_issue_ctrl
    import sb_pkg::*;
#(
    parameter int REG_COUNT = 32,
    parameter int OP_W      = 6
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [OP_W-1:0]               in_op,
    input  logic [$clog2(REG_COUNT)-1:0]  in_dest,
    input  logic [$clog2(REG_COUNT)-1:0]  in_src1,
    input  logic [$clog2(REG_COUNT)-1:0]  in_src2,
    input  logic [UNIT_IDX_W-1:0]         in_unit,
    input  logic [UNIT_COUNT-1:0]         unit_done,
    output logic                          issue_ok,
    output logic [UNIT_COUNT-1:0]         rd_grant,
    output logic [UNIT_COUNT-1:0]         wb_grant,
    output logic [UNIT_COUNT*OP_W-1:0]    unit_op
);
    localparam int RW = $clog2(REG_COUNT);
    localparam int NU = UNIT_COUNT;
    localparam int UW = UNIT_IDX_W;

    logic            busy     [NU];
    logic            ops_read [NU];
    logic            rj       [NU];
    logic            rk       [NU];
    logic [RW-1:0]   fi       [NU];
    logic [RW-1:0]   fj       [NU];
    logic [RW-1:0]   fk       [NU];
    logic [OP_W-1:0] op_q     [NU];

    logic            a_v, b_v, d_v;
    logic [UW-1:0]   a_unit, b_unit;
    logic            wb_any;
    logic [UW-1:0]   wb_idx;
    logic [NU-1:0]   wb_req, war_block, alloc_vec, rd_vec;
    logic            qj_pend, qk_pend;

    // Issue check: target unit idle and destination not claimed.
    assign issue_ok = in_valid && !busy[in_unit] && !d_v;

    // A source whose producer writes back this cycle counts as already produced.
    assign qj_pend = a_v && !(wb_any && (a_unit == wb_idx));
    assign qk_pend = b_v && !(wb_any && (b_unit == wb_idx));

    // Steer the accepted instruction to its unit record.
    always_comb begin
        alloc_vec          = '0;
        alloc_vec[in_unit] = issue_ok;
    end

    // WAR guard: some other unit still has to read this unit's destination.
    always_comb begin
        for (int u = 0; u < NU; u++) begin
            war_block[u] = 1'b0;
            for (int v = 0; v < NU; v++) begin
                if ((v != u) && busy[v] &&
                    (((fj[v] == fi[u]) && rj[v]) || ((fk[v] == fi[u]) && rk[v])))
                    war_block[u] = 1'b1;
            end
        end
    end

    genvar g;
    generate
        for (g = 0; g < NU; g++) begin : g_unit
            sb_unit_slot #(.RW(RW), .OP_W(OP_W), .UW(UW)) u_slot (
                .clk        (clk),
                .rst_n      (rst_n),
                .alloc      (alloc_vec[g]),
                .alloc_op   (in_op),
                .alloc_fi   (in_dest),
                .alloc_fj   (in_src1),
                .alloc_fk   (in_src2),
                .alloc_qj_v (qj_pend),
                .alloc_qj   (a_unit),
                .alloc_qk_v (qk_pend),
                .alloc_qk   (b_unit),
                .read_go    (rd_vec[g]),
                .retire     (wb_grant[g]),
                .bcast_v    (wb_any),
                .bcast_unit (wb_idx),
                .busy       (busy[g]),
                .ops_read   (ops_read[g]),
                .op         (op_q[g]),
                .fi         (fi[g]),
                .fj         (fj[g]),
                .fk         (fk[g]),
                .rj         (rj[g]),
                .rk         (rk[g])
            );

            // Operand read once both sources are produced and not yet read.
            assign rd_vec[g] = busy[g] && !ops_read[g] && rj[g] && rk[g];
            // Write-back request: executed, reported done, no WAR conflict.
            assign wb_req[g] = busy[g] && ops_read[g] && unit_done[g] && !war_block[g];
            assign unit_op[g*OP_W +: OP_W] = op_q[g];
        end
    endgenerate

    assign rd_grant = rd_vec;

    sb_result_table #(.REG_COUNT(REG_COUNT), .UW(UW)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (issue_ok),
        .set_reg  (in_dest),
        .set_unit (in_unit),
        .clr_en   (wb_any),
        .clr_reg  (fi[wb_idx]),
        .look_a   (in_src1),
        .look_b   (in_src2),
        .look_d   (in_dest),
        .a_v      (a_v),
        .a_unit   (a_unit),
        .b_v      (b_v),
        .b_unit   (b_unit),
        .d_v      (d_v)
    );

    sb_wb_picker #(.N(NU), .UW(UW)) u_pick (
        .req   (wb_req),
        .grant (wb_grant),
        .any   (wb_any),
        .idx   (wb_idx)
    );
endmodule

// File: rtl/sb_issue_ctrl_chk.sv
// Protocol checker for the scoreboard issue controller, attached by bind.
// Observes the ports plus the destination-pending lookup of the result table.
module sb_issue_ctrl_chk #(
    parameter int NU = 4,
    parameter int UW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [UW-1:0] in_unit,
    input logic          issue_ok,
    input logic [NU-1:0] rd_grant,
    input logic [NU-1:0] wb_grant,
    input logic [NU-1:0] unit_done,
    input logic          dest_pending
);
    assert_one_writer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wb_grant));

    assert_wb_needs_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((wb_grant & ~unit_done) == '0));

    assert_no_read_and_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_grant & wb_grant) == '0));

    assert_read_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|rd_grant) |=> ((rd_grant & $past(rd_grant)) == '0));

    assert_waw_refused_R3: assert property (@(posedge clk) disable iff (!rst_n)
        issue_ok |-> !dest_pending);

    assert_issue_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_ok |-> in_valid);

    assert_no_wb_after_issue_R9: assert property (@(posedge clk) disable iff (!rst_n)
        issue_ok |=> !wb_grant[$past(in_unit)]);
endmodule

bind sb_issue_ctrl sb_issue_ctrl_chk #(.NU(sb_pkg::UNIT_COUNT), .UW(sb_pkg::UNIT_IDX_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_unit      (in_unit),
    .issue_ok     (issue_ok),
    .rd_grant     (rd_grant),
    .wb_grant     (wb_grant),
    .unit_done    (unit_done),
    .dest_pending (d_v)
);

// File: tb/sb_issue_ctrl_test.sv
// Directed bench: fixed-latency unit models, one task per scenario.
module sb_issue_ctrl_test;
    import sb_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [5:0]  in_op = '0;
    logic [4:0]  in_dest = '0, in_src1 = '0, in_src2 = '0;
    logic [1:0]  in_unit = '0;
    logic [3:0]  unit_done;
    logic        issue_ok;
    logic [3:0]  rd_grant, wb_grant;
    logic [23:0] unit_op;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sb_issue_ctrl uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_dest(in_dest), .in_src1(in_src1), .in_src2(in_src2), .in_unit(in_unit),
        .unit_done(unit_done), .issue_ok(issue_ok), .rd_grant(rd_grant),
        .wb_grant(wb_grant), .unit_op(unit_op)
    );

    // Unit models: latency counted from the read grant, done held until write-back.
    int         lat [4] = '{1, 3, 2, 6};
    int         cnt [4];
    logic [3:0] done_r;
    assign unit_done = done_r;

    always @(posedge clk) begin
        for (int u = 0; u < 4; u++) begin
            if (!rst_n) begin
                cnt[u]    <= 0;
                done_r[u] <= 1'b0;
            end else if (wb_grant[u]) begin
                done_r[u] <= 1'b0;
            end else if (rd_grant[u]) begin
                cnt[u] <= lat[u];
            end else if (cnt[u] != 0) begin
                cnt[u] <= cnt[u] - 1;
                if (cnt[u] == 1) done_r[u] <= 1'b1;
            end
        end
    end

    // Grant log sampled mid-cycle.
    int         rd_at [4], wb_at [4], rd_n [4], wb_n [4];
    logic [5:0] op_seen [4];
    always @(negedge clk) begin
        if (rst_n) begin
            for (int u = 0; u < 4; u++) begin
                if (rd_grant[u]) begin
                    rd_at[u] = cyc;
                    rd_n[u]  = rd_n[u] + 1;
                    op_seen[u] = unit_op[u*6 +: 6];
                end
                if (wb_grant[u]) begin
                    wb_at[u] = cyc;
                    wb_n[u]  = wb_n[u] + 1;
                end
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_log();
        for (int u = 0; u < 4; u++) begin
            rd_at[u] = -1; wb_at[u] = -1; rd_n[u] = 0; wb_n[u] = 0;
        end
    endtask

    task automatic settle();
        repeat (25) @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Present one instruction and hold it until accepted.
    task automatic issue(input logic [5:0] op, input logic [4:0] d, input logic [4:0] s1,
                         input logic [4:0] s2, input logic [1:0] u,
                         output int pres, output int acc);
        in_valid = 1'b1; in_op = op; in_dest = d; in_src1 = s1; in_src2 = s2; in_unit = u;
        pres = cyc;
        acc  = -1;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (issue_ok) begin
                acc = cyc;
                break;
            end
            @(posedge clk); #1;
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
        if (acc < 0) chk("R2", "instruction never accepted", 0, 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle(3);
        @(negedge clk);
        chk("R1", "issue_ok in reset", int'(issue_ok), 0);
        chk("R1", "rd_grant in reset", int'(rd_grant), 0);
        chk("R1", "wb_grant in reset", int'(wb_grant), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        idle(2);
        @(negedge clk);
        chk("R1", "rd_grant after reset", int'(rd_grant), 0);
        chk("R1", "wb_grant after reset", int'(wb_grant), 0);
        chk("R1", "issue_ok after reset", int'(issue_ok), 0);
        @(posedge clk); #1;
    endtask

    task automatic t_basic();
        int p, a;
        clear_log();
        issue(6'h2A, 5'd1, 5'd2, 5'd3, CLS_ADD, p, a);
        chk("R1", "first instruction accepted when presented", a, p);
        settle();
        chk("R6", "read grant one cycle after issue", rd_at[2], a + 1);
        chk("R6", "read grant count", rd_n[2], 1);
        chk("R11", "unit_op slice at read", int'(op_seen[2]), 'h2A);
        chk("R9", "write-back after done", wb_at[2], rd_at[2] + 3);
        chk("R9", "write-back count", wb_n[2], 1);
    endtask

    task automatic t_structural();
        int p1, a1, p2, a2;
        clear_log();
        issue(6'h11, 5'd4, 5'd1, 5'd2, CLS_MUL, p1, a1);
        issue(6'h12, 5'd5, 5'd1, 5'd2, CLS_MUL, p2, a2);
        chk("R2", "busy unit refused at first", int'(a2 > p2), 1);
        chk("R2", "accepted after unit write-back", a2, wb_at[1] + 1);
        settle();
        chk("R2", "second multiply read", rd_at[1], a2 + 1);
    endtask

    task automatic t_waw();
        int p1, a1, p2, a2;
        clear_log();
        issue(6'h21, 5'd6, 5'd1, 5'd2, CLS_DIV, p1, a1);
        issue(6'h22, 5'd6, 5'd3, 5'd4, CLS_ADD, p2, a2);
        chk("R3", "same destination refused at first", int'(a2 > p2), 1);
        chk("R3", "accepted after writer write-back", a2, wb_at[3] + 1);
        settle();
    endtask

    task automatic t_raw_ooo();
        int p, a;
        clear_log();
        issue(6'h31, 5'd7, 5'd1, 5'd2, CLS_DIV, p, a);
        issue(6'h32, 5'd8, 5'd7, 5'd3, CLS_ADD, p, a);
        issue(6'h33, 5'd9, 5'd4, 5'd5, CLS_MUL, p, a);
        settle();
        chk("R5", "independent later read first", int'(rd_at[1] < rd_at[2]), 1);
        chk("R4", "dependent read after producer", rd_at[2], wb_at[3] + 1);
    endtask

    task automatic t_war();
        int p, a;
        clear_log();
        issue(6'h01, 5'd10, 5'd1, 5'd2, CLS_DIV, p, a);
        issue(6'h02, 5'd11, 5'd10, 5'd12, CLS_ADD, p, a);
        issue(6'h03, 5'd12, 5'd3, 5'd3, CLS_INT, p, a);
        settle();
        chk("R4", "reader waits on producer", rd_at[2], wb_at[3] + 1);
        chk("R7", "writer held past its done", int'(wb_at[0] > rd_at[0] + 2), 1);
        chk("R7", "writer released after old value read", wb_at[0], rd_at[2] + 1);
    endtask

    task automatic t_priority();
        int p, a;
        clear_log();
        issue(6'h05, 5'd15, 5'd1, 5'd2, CLS_ADD, p, a);
        issue(6'h06, 5'd16, 5'd1, 5'd2, CLS_INT, p, a);
        settle();
        chk("R8", "lowest index wins when both done", wb_at[0], rd_at[2] + 3);
        chk("R8", "loser granted next cycle", wb_at[2], wb_at[0] + 1);
    endtask

    task automatic t_same_cycle();
        int p, a, p2, a2;
        clear_log();
        issue(6'h07, 5'd13, 5'd1, 5'd2, CLS_INT, p, a);
        idle(2);
        issue(6'h08, 5'd14, 5'd13, 5'd1, CLS_MUL, p2, a2);
        chk("R10", "consumer accepted in producer write-back cycle", a2, wb_at[0]);
        settle();
        chk("R10", "consumer read next cycle", rd_at[1], a2 + 1);
        chk("R10", "consumer written back", wb_n[1], 1);
    endtask

    initial begin
        clear_log();
        t_reset();
        t_basic();
        t_structural();
        t_waw();
        t_raw_ooo();
        t_war();
        t_priority();
        t_same_cycle();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R1 watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule